// File: doc/BRIEF.md
# Microprogram Sequencer with OR-Merged Branch Targets

This block is the control unit of a bus-oriented processor that is driven by a microprogram. A micro-address register selects one word of a small constant control store. The block decodes that word into datapath enables: register-in, register-out and auxiliary-latch selects, an ALU function code, a memory read or write request, a carry-in flag, a wait-for-memory flag and an end-of-instruction flag. The datapath itself is outside this block. The block receives the instruction register contents, the negative flag of the datapath and the memory-complete handshake.

The micro-address normally steps by one. There are four exceptions. While a word asks to wait for memory and the handshake is low, it holds. An end step sends it back to the fetch routine. A jump step loads the word's own address field. A dispatch step ORs selected instruction bits into the word's base address. This produces several targets from one control word: one per source addressing mode after the fetch, and one for each of the direct and indirect operand paths. A conditional step returns to fetch when the negative flag is clear.

Top module: `useq_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets `upc` to 0. The following cycle then starts at the fetch routine.
- R2: A step with no wait, end, jump or dispatch advances `upc` by exactly one. The fetch routine occupies addresses 0, 1, 2 and then 3.
- R3: `wait_mem` is high exactly at addresses 1, 83 (octal 123) and 120 (octal 170). While `wait_mem` is high and `mfc` is low, `upc` and all select outputs keep their values. The first edge with `mfc` high moves on.
- R4: After a step with `end_step` high, `upc` is 0 on the next cycle.
- R5: Address 3 dispatches to octal 101 with IR[10:9] ORed into bits 5:4. Bit 3 is also set when IR[10:9]=00 and IR[8]=1. The targets are 65 (mode 00, IR8=0), 73 (mode 00, IR8=1), 81 (mode 01), 97 (mode 10) and 113 (mode 11).
- R6: Address 83 dispatches to 120 when IR[8]=1 and to 121 when IR[8]=0. An IR8=1 operand therefore takes one extra memory step.
- R7: Address 73 is conditional. With `n_flag` low it goes to 0. With `n_flag` high it goes to 74.
- R8: Each 4-bit register field is decoded so that code k drives select bit k only, and code 0 drives no bit. The select ports are never more than one-hot. Address 3 drives no select. At address 67 `reg_in_sel` is bit 2 (destination register).
- R9: The fetch words do the following. Address 0 drives `reg_out_sel` bit 3 (PC), `aux_in_sel` bit 1 (MAR), `mem_read`, `carry_set` and `alu_fn`=1 (add). Address 2 drives `reg_out_sel` bit 5 (MDR) and `aux_in_sel` bit 4 (IR).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ir_word | input | 16 | Instruction register contents; bits 10:8 steer dispatch |
| n_flag | input | 1 | Negative condition flag from the datapath |
| mfc | input | 1 | Memory operation complete |
| upc | output | 8 | Current micro-address |
| reg_in_sel | output | 16 | One-hot register load enables |
| reg_out_sel | output | 16 | One-hot register drive-to-bus enables |
| aux_in_sel | output | 16 | One-hot enables for MAR, Y, IR latches |
| alu_fn | output | 4 | ALU function code |
| mem_read | output | 1 | Memory read request |
| mem_write | output | 1 | Memory write request |
| carry_set | output | 1 | ALU carry-in |
| wait_mem | output | 1 | Current step waits for `mfc` |
| end_step | output | 1 | Last step of the instruction |

## Verification
The checker watches every cycle for the following: the hold while memory is outstanding, the return to 0 after an end step, the bit pattern of both dispatch targets relative to the IR bits one cycle earlier, at-most-one-hot selects, and the reset target. Only the bench's scenarios can show complete micro-address traces for each addressing mode and indirection choice. The same is true of the negative-flag fork, the exact field decoding at chosen addresses, and a reset that lands in the middle of an instruction. The bench drives random memory latencies throughout.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int UPC_W  = 8;
    localparam int CODE_W = 4;

    typedef enum logic [2:0] {
        SQ_INC   = 3'd0,
        SQ_MODE  = 3'd1,
        SQ_IND   = 3'd2,
        SQ_NZERO = 3'd3,
        SQ_GO    = 3'd4
    } seq_e;

    typedef struct packed {
        seq_e              seq;
        logic [UPC_W-1:0]  nxa;
        logic [CODE_W-1:0] rin;
        logic [CODE_W-1:0] rout;
        logic [CODE_W-1:0] oin;
        logic [CODE_W-1:0] alu;
        logic [1:0]        mem;
        logic              cin;
        logic              wmfc;
        logic              fin;
    } uword_t;

    typedef struct packed {
        logic [UPC_W-1:0] upc;
    } seq_state_t;

    // register bus codes
    localparam logic [CODE_W-1:0] RC_NONE = 4'd0;
    localparam logic [CODE_W-1:0] RC_SRC  = 4'd1;
    localparam logic [CODE_W-1:0] RC_DST  = 4'd2;
    localparam logic [CODE_W-1:0] RC_PC   = 4'd3;
    localparam logic [CODE_W-1:0] RC_Z    = 4'd4;
    localparam logic [CODE_W-1:0] RC_MDR  = 4'd5;
    localparam logic [CODE_W-1:0] RC_OFS  = 4'd6;
    // auxiliary latch codes
    localparam logic [CODE_W-1:0] OC_MAR  = 4'd1;
    localparam logic [CODE_W-1:0] OC_Y    = 4'd2;
    localparam logic [CODE_W-1:0] OC_IR   = 4'd4;
    // ALU codes
    localparam logic [CODE_W-1:0] AF_ADD  = 4'd1;
    localparam logic [CODE_W-1:0] AF_SUB  = 4'd2;
    // memory codes
    localparam logic [1:0] MC_NOP = 2'b00;
    localparam logic [1:0] MC_RD  = 2'b01;
    localparam logic [1:0] MC_WR  = 2'b10;

    function automatic uword_t ustore(input logic [UPC_W-1:0] a);
        uword_t w;
        w     = '0;
        w.seq = SQ_INC;
        w.mem = MC_NOP;
        case (a)
            // fetch
            8'd0: begin
                w.rout = RC_PC; w.oin = OC_MAR; w.mem = MC_RD;
                w.cin = 1'b1; w.alu = AF_ADD;
            end
            8'd1: begin w.rout = RC_Z; w.rin = RC_PC; w.wmfc = 1'b1; end
            8'd2: begin w.rout = RC_MDR; w.oin = OC_IR; end
            8'd3: begin w.seq = SQ_MODE; w.nxa = 8'o101; end
            // register mode, plain
            8'o101: begin w.rout = RC_SRC; w.oin = OC_Y; end
            8'o102: begin w.rout = RC_DST; w.alu = AF_ADD; end
            8'o103: begin w.rout = RC_Z; w.rin = RC_DST; w.fin = 1'b1; end
            // register mode, flagged: relative jump when negative
            8'o111: begin
                w.rout = RC_PC; w.oin = OC_Y; w.seq = SQ_NZERO; w.nxa = 8'd0;
            end
            8'o112: begin w.rout = RC_OFS; w.alu = AF_ADD; end
            8'o113: begin w.rout = RC_Z; w.rin = RC_PC; w.fin = 1'b1; end
            // post-increment source
            8'o121: begin
                w.rout = RC_SRC; w.oin = OC_MAR; w.mem = MC_RD;
                w.cin = 1'b1; w.alu = AF_ADD;
            end
            8'o122: begin w.rout = RC_Z; w.rin = RC_SRC; end
            8'o123: begin w.seq = SQ_IND; w.nxa = 8'o170; w.wmfc = 1'b1; end
            8'o170: begin
                w.rout = RC_MDR; w.oin = OC_MAR; w.mem = MC_RD; w.wmfc = 1'b1;
            end
            8'o171: begin w.rout = RC_MDR; w.oin = OC_Y; end
            8'o172: begin w.rout = RC_DST; w.alu = AF_ADD; end
            8'o173: begin w.rout = RC_Z; w.rin = RC_DST; w.fin = 1'b1; end
            // pre-decrement source
            8'o141: begin w.rout = RC_SRC; w.alu = AF_SUB; end
            8'o142: begin w.rout = RC_Z; w.rin = RC_SRC; w.fin = 1'b1; end
            // indexed
            8'o161: begin w.rout = RC_DST; w.oin = OC_MAR; w.fin = 1'b1; end
            default: w.fin = 1'b1;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/useq_store.sv
module useq_store
    import useq_pkg::*;
(
    input  logic [UPC_W-1:0] addr,
    output uword_t           word
);
    always_comb begin
        word = ustore(addr);
    end
endmodule

// File: rtl/useq_onehot.sv
module useq_onehot #(
    parameter int CODE_W = 4,
    localparam int SEL_W = 1 << CODE_W
) (
    input  logic [CODE_W-1:0] code,
    output logic [SEL_W-1:0]  sel
);
    for (genvar g = 0; g < SEL_W; g++) begin : g_bit
        if (g == 0) begin : g_none
            assign sel[g] = 1'b0;
        end else begin : g_dec
            assign sel[g] = (code == CODE_W'(g));
        end
    end
endmodule

// File: rtl/useq_next.sv
module useq_next
    import useq_pkg::*;
(
    input  logic [UPC_W-1:0] upc_q,
    input  uword_t           word,
    input  logic [1:0]       ir_mode,
    input  logic             ir_ind,
    input  logic             n_flag,
    input  logic             mfc,
    output logic [UPC_W-1:0] upc_nx
);
    logic             plain_reg;
    logic [UPC_W-1:0] mode_or;

    always_comb begin
        plain_reg = ~ir_mode[1] & ~ir_mode[0] & ir_ind;
        mode_or   = {2'b00, ir_mode, plain_reg, 3'b000};
        upc_nx    = upc_q + 1'b1;
        if (word.wmfc && !mfc) begin
            upc_nx = upc_q;
        end else if (word.fin) begin
            upc_nx = '0;
        end else begin
            case (word.seq)
                SQ_MODE:  upc_nx = word.nxa | mode_or;
                SQ_IND:   upc_nx = word.nxa | {{(UPC_W-1){1'b0}}, ~ir_ind};
                SQ_NZERO: if (!n_flag) upc_nx = word.nxa;
                SQ_GO:    upc_nx = word.nxa;
                default:  upc_nx = upc_q + 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
    import useq_pkg::*;
#(
    parameter int IR_W = 16,
    localparam int SEL_W = 1 << CODE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IR_W-1:0]  ir_word,
    input  logic             n_flag,
    input  logic             mfc,
    output logic [UPC_W-1:0] upc,
    output logic [SEL_W-1:0] reg_in_sel,
    output logic [SEL_W-1:0] reg_out_sel,
    output logic [SEL_W-1:0] aux_in_sel,
    output logic [3:0]       alu_fn,
    output logic             mem_read,
    output logic             mem_write,
    output logic             carry_set,
    output logic             wait_mem,
    output logic             end_step
);
    seq_state_t       st_d, st_q;
    uword_t           word;
    logic [UPC_W-1:0] upc_nx;
    logic             unused_ir;

    assign unused_ir = ^{ir_word[IR_W-1:11], ir_word[7:0]};

    useq_store i_store (
        .addr (st_q.upc),
        .word (word)
    );

    useq_next i_next (
        .upc_q   (st_q.upc),
        .word    (word),
        .ir_mode (ir_word[10:9]),
        .ir_ind  (ir_word[8]),
        .n_flag  (n_flag),
        .mfc     (mfc),
        .upc_nx  (upc_nx)
    );

    useq_onehot #(.CODE_W(CODE_W)) i_dec_in  (.code(word.rin),  .sel(reg_in_sel));
    useq_onehot #(.CODE_W(CODE_W)) i_dec_out (.code(word.rout), .sel(reg_out_sel));
    useq_onehot #(.CODE_W(CODE_W)) i_dec_aux (.code(word.oin),  .sel(aux_in_sel));

    always_comb begin
        st_d = st_q;
        if (rst) st_d.upc = '0;
        else     st_d.upc = upc_nx;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign upc       = st_q.upc;
    assign alu_fn    = word.alu;
    assign mem_read  = (word.mem == MC_RD);
    assign mem_write = (word.mem == MC_WR);
    assign carry_set = word.cin;
    assign wait_mem  = word.wmfc;
    assign end_step  = word.fin;
endmodule

// File: rtl/useq_checks.sv
module useq_checks #(
    parameter int UPC_W = 8,
    parameter int SEL_W = 16,
    parameter int IR_W  = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [IR_W-1:0]  ir_word,
    input logic             mfc,
    input logic [UPC_W-1:0] upc,
    input logic [SEL_W-1:0] reg_in_sel,
    input logic [SEL_W-1:0] reg_out_sel,
    input logic [SEL_W-1:0] aux_in_sel,
    input logic             wait_mem,
    input logic             end_step
);
    assert_reset_zero_R1: assert property (@(posedge clk)
        rst |=> (upc == '0));

    assert_hold_wait_R3: assert property (@(posedge clk) disable iff (rst)
        (wait_mem && !mfc) |=> ($stable(upc) && $stable(reg_out_sel) && $stable(aux_in_sel)));

    assert_end_fetch_R4: assert property (@(posedge clk) disable iff (rst)
        (end_step && !(wait_mem && !mfc)) |=> (upc == '0));

    assert_mode_target_R5: assert property (@(posedge clk) disable iff (rst)
        (upc == 8'd3) |=> (upc[7:6] == 2'b01 && upc[2:0] == 3'b001
                           && upc[5:4] == $past(ir_word[10:9])));

    assert_ind_target_R6: assert property (@(posedge clk) disable iff (rst)
        (upc == 8'o123 && mfc) |=> (upc[7:1] == 7'b0111100 && upc[0] == !$past(ir_word[8])));

    assert_sel_onehot_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(reg_in_sel) && $onehot0(reg_out_sel) && $onehot0(aux_in_sel)
        && !reg_in_sel[0] && !reg_out_sel[0] && !aux_in_sel[0]);
endmodule

bind useq_ctrl useq_checks i_checks (.*);

// File: tb/test_useq_ctrl.sv
module test_useq_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] ir_word = '0;
    logic        n_flag = 1'b0;
    logic        mfc = 1'b0;
    logic [7:0]  upc;
    logic [15:0] reg_in_sel, reg_out_sel, aux_in_sel;
    logic [3:0]  alu_fn;
    logic        mem_read, mem_write, carry_set, wait_mem, end_step;

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    finished = 1'b0;
    int    p_addr [16];
    string p_tag  [16];
    int    p_len;

    always #5 clk = ~clk;

    useq_ctrl i_useq_ctrl (
        .clk(clk), .rst(rst), .ir_word(ir_word), .n_flag(n_flag), .mfc(mfc),
        .upc(upc), .reg_in_sel(reg_in_sel), .reg_out_sel(reg_out_sel),
        .aux_in_sel(aux_in_sel), .alu_fn(alu_fn), .mem_read(mem_read),
        .mem_write(mem_write), .carry_set(carry_set), .wait_mem(wait_mem),
        .end_step(end_step)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic push(input int a, input string t);
        p_addr[p_len] = a;
        p_tag[p_len]  = t;
        p_len++;
    endtask

    // expected micro-address trace from the requirements
    task automatic build_path(input logic [15:0] irv, input bit nv, input string first);
        logic [1:0] md;
        md    = irv[10:9];
        p_len = 0;
        push(0, first); push(1, "R2"); push(2, "R2"); push(3, "R2");
        case (md)
            2'b00: if (!irv[8]) begin
                push(65, "R5"); push(66, "R2"); push(67, "R2");
            end else begin
                push(73, "R5");
                if (nv) begin push(74, "R7"); push(75, "R2"); end
            end
            2'b01: begin
                push(81, "R5"); push(82, "R2"); push(83, "R2");
                if (irv[8]) push(120, "R6");
                push(121, irv[8] ? "R2" : "R6"); push(122, "R2"); push(123, "R2");
            end
            2'b10: begin push(97, "R5"); push(98, "R2"); end
            default: push(113, "R5");
        endcase
    endtask

    task automatic run_instr(input logic [15:0] irv, input bit nv, input string first);
        int  i;
        bit  hold, w, was_hold;
        int  a;
        build_path(irv, nv, first);
        ir_word  = irv;
        n_flag   = nv;
        i        = 0;
        was_hold = 1'b0;
        while (i < p_len) begin
            a = p_addr[i];
            w = (a == 1) || (a == 83) || (a == 120);
            chk(upc == 8'(a), was_hold ? "R3" : p_tag[i], upc, a);
            chk(wait_mem == w, "R3", wait_mem, w);
            if (a == 0) begin
                chk(reg_out_sel == 16'h0008, "R9", reg_out_sel, 16'h0008);
                chk(aux_in_sel == 16'h0002 && mem_read && carry_set && alu_fn == 4'd1,
                    "R9", aux_in_sel, 16'h0002);
            end
            if (a == 2)
                chk(reg_out_sel == 16'h0020 && aux_in_sel == 16'h0010, "R9", reg_out_sel, 16'h0020);
            if (a == 3)
                chk(reg_in_sel == 0 && reg_out_sel == 0 && aux_in_sel == 0, "R8", reg_out_sel, 0);
            if (a == 67)
                chk(reg_in_sel == 16'h0004, "R8", reg_in_sel, 16'h0004);
            hold = w && ($urandom % 3 == 0);
            mfc  = w ? !hold : 1'($urandom % 2);
            @(posedge clk);
            @(negedge clk);
            was_hold = hold;
            if (!hold) i++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] r;
        void'($urandom(32'd7351));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(upc == 0, "R1", upc, 0);
        chk(reg_in_sel == 0, "R8", reg_in_sel, 0);
        rst = 1'b0;

        // directed: every mode, both IR8 values, both N values
        run_instr(16'h0200, 1'b0, "R1");
        run_instr(16'h0300, 1'b0, "R4");
        run_instr(16'h0000, 1'b1, "R4");
        run_instr(16'h0100, 1'b0, "R4");
        run_instr(16'h0100, 1'b1, "R7");
        run_instr(16'h0400, 1'b1, "R4");
        run_instr(16'h0600, 1'b0, "R4");
        run_instr(16'h0500, 1'b0, "R4");
        run_instr(16'h0700, 1'b1, "R4");

        // constrained random instructions
        for (int k = 0; k < 60; k++) begin
            r = 16'($urandom);
            run_instr(r, 1'($urandom % 2), "R4");
        end

        // reset in the middle of an operand sequence (R1)
        ir_word = 16'h0200;
        mfc     = 1'b1;
        for (int k = 0; k < 30; k++) begin
            if (upc == 8'd82) break;
            @(posedge clk); @(negedge clk);
        end
        chk(upc == 8'd82, "R2", upc, 82);
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        chk(upc == 0, "R1", upc, 0);
        rst = 1'b0;
        run_instr(16'h0300, 1'b0, "R1");
        chk(upc == 0, "R4", upc, 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule